// File: doc/BRIEF.md
# Serial-Grant Bus Arbiter

This block lets several devices share one bus. Each device has its own interface cell, and the cells are chained in a fixed physical order. Every request pin feeds one combined request line that the central controller watches. When that line is active and the bus is free, the controller pulses a single grant into the head of the chain. Device 0 sits at the head and has the highest priority. The last device has the lowest.

A cell whose device is not asking for the bus passes the grant combinationally to the next cell. The first cell that sees both the grant and its own request stops the grant and takes the bus. That cell holds ownership until its device drives the shared release line. Release pins of devices that do not own the bus are masked. Nothing in the block enforces fairness, so a device that keeps requesting near the head can lock out devices further down indefinitely.

The device count `N_DEV` ranges from 2 to 16. The grant path is purely combinational through the cells, so its delay grows with the device count. A parameter chooses how the combined request, take and release lines are reduced: either a balanced OR or a ripple that follows the chain.

Top module: `chain_arbiter`

## Requirements
- R1: While `rst_n` is low, every `dev_own_o` bit and `grant_o` are 0. Reset is asynchronous and takes effect without a clock edge.
- R2: The controller sees all `dev_req_i` bits as one combined request. With the bus free, any single request raises `grant_o` after the next rising edge. The requesting device's `dev_own_o` bit goes to 1 one edge later.
- R3: When several devices request during the same grant pulse, the device with the lowest index becomes owner. Bit i of each vector belongs to device i.
- R4: While a device owns the bus, requests from other devices and a dropped request from the owner do not change `dev_own_o`.
- R5: A `dev_rel_i` bit from a device that does not own the bus has no effect.
- R6: When the owner's `dev_rel_i` bit is high at a rising edge, its `dev_own_o` bit clears on that edge. `grant_o` then stays low for one more cycle before the next pending requester is offered the bus.
- R7: `grant_o` is high for exactly one cycle per offer, and it is never high while any `dev_own_o` bit is set.
- R8: At most one `dev_own_o` bit is 1 at any time.
- R9: If every request is withdrawn while the grant is in flight, the grant leaves the tail of the chain. No device becomes owner and the controller returns to idle.
- R10: A device with a higher index gets no ownership while a device with a lower index keeps requesting again after each release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | N_DEV | Per-device bus request; bit 0 is the head of the chain |
| dev_rel_i | input | N_DEV | Per-device release strobe; only the owner's bit counts |
| dev_own_o | output | N_DEV | Per-device bus-owned flag |
| grant_o | output | 1 | Grant pulse entering the head of the chain |

## Verification
Each result has a fixed latency. `grant_o` rises one rising edge after a request reaches an idle controller. Ownership follows one edge after that. A release clears ownership on the edge where it is sampled, and the next owner appears two edges after that release. The bench applies each stimulus vector at a falling edge and compares both outputs 1 ns after the following rising edge. Each table entry therefore states the outputs expected right after exactly one edge, so every latency above shows up as a sequence of entries. Directed checks of asynchronous reset compare the outputs a moment after `rst_n` falls, with no clock edge in between.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;

   localparam int unsigned DEV_MIN = 2;
   localparam int unsigned DEV_MAX = 16;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_OFFER = 2'd1,
      ARB_HELD  = 2'd2
   } arb_state_e;

   function automatic bit dev_count_ok(input int unsigned n);
      return (n >= DEV_MIN) && (n <= DEV_MAX);
   endfunction

endpackage

// File: rtl/chain_arb_or.sv
module chain_arb_or #(
   parameter int unsigned WIDTH = 4,
   parameter bit          FLAT  = 1'b1
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic             any_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("chain_arb_or: WIDTH must be at least 1");
   end

   if (FLAT) begin : g_flat
      assign any_o = |bits_i;
   end else begin : g_ripple
      logic [WIDTH:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign acc[i+1] = acc[i] | bits_i[i];
      end
      assign any_o = acc[WIDTH];
   end

endmodule

// File: rtl/chain_arb_cell.sv
module chain_arb_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_in_i,
   input  logic req_i,
   input  logic rel_i,
   output logic grant_out_o,
   output logic take_o,
   output logic owned_o,
   output logic rel_o
);

   logic owned_q;
   logic owned_d;

   // A cell that wants the bus stops the grant here.
   assign take_o      = grant_in_i & req_i;
   assign grant_out_o = grant_in_i & ~req_i;
   // Only the owner may drive the shared release line.
   assign rel_o       = owned_q & rel_i;
   assign owned_o     = owned_q;

   always_comb begin
      owned_d = owned_q;
      if (owned_q) begin
         if (rel_i) owned_d = 1'b0;
      end else if (take_o) begin
         owned_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owned_q <= 1'b0;
      else        owned_q <= owned_d;
   end

   // R4
   owned_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (owned_q && !rel_i) |=> owned_q);

   // R2
   owned_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owned_q) |-> $past(grant_in_i && req_i));

endmodule

// File: rtl/chain_arb_ctrl.sv
module chain_arb_ctrl
   import chain_arb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_req_i,
   input  logic bus_take_i,
   input  logic bus_rel_i,
   input  logic grant_tail_i,
   output logic grant_o
);

   arb_state_e state_q;
   arb_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_IDLE:  if (bus_req_i) state_d = ARB_OFFER;
         // The offer lasts one cycle: either a cell took it, or it ran off the tail.
         ARB_OFFER: state_d = bus_take_i ? ARB_HELD : ARB_IDLE;
         ARB_HELD:  if (bus_rel_i) state_d = ARB_IDLE;
         default:   state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign grant_o = (state_q == ARB_OFFER);

   // R7
   grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |=> !grant_o);

   // R9
   grant_resolved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> (bus_take_i ^ grant_tail_i));

   // R6
   gap_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rel_i && !grant_o) |=> !grant_o);

endmodule

// File: rtl/chain_arbiter.sv
module chain_arbiter
   import chain_arb_pkg::*;
#(
   parameter int unsigned N_DEV    = 8,
   parameter bit          FLAT_OR  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_DEV-1:0] dev_req_i,
   input  logic [N_DEV-1:0] dev_rel_i,
   output logic [N_DEV-1:0] dev_own_o,
   output logic             grant_o
);

   localparam int unsigned LINK_W = N_DEV + 1;

   if (!dev_count_ok(N_DEV)) begin : g_bad_count
      $error("chain_arbiter: N_DEV must lie between 2 and 16");
   end

   logic [LINK_W-1:0] grant_link;
   logic [N_DEV-1:0]  take_vec;
   logic [N_DEV-1:0]  rel_vec;
   logic              bus_req;
   logic              bus_take;
   logic              bus_rel;
   logic              grant_w;

   chain_arb_or #(.WIDTH(N_DEV), .FLAT(FLAT_OR)) u_req_or (
      .bits_i (dev_req_i),
      .any_o  (bus_req)
   );

   chain_arb_or #(.WIDTH(N_DEV), .FLAT(FLAT_OR)) u_take_or (
      .bits_i (take_vec),
      .any_o  (bus_take)
   );

   chain_arb_or #(.WIDTH(N_DEV), .FLAT(FLAT_OR)) u_rel_or (
      .bits_i (rel_vec),
      .any_o  (bus_rel)
   );

   chain_arb_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_req_i    (bus_req),
      .bus_take_i   (bus_take),
      .bus_rel_i    (bus_rel),
      .grant_tail_i (grant_link[N_DEV]),
      .grant_o      (grant_w)
   );

   assign grant_link[0] = grant_w;
   assign grant_o       = grant_w;

   for (genvar i = 0; i < N_DEV; i++) begin : g_cell
      chain_arb_cell u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .grant_in_i  (grant_link[i]),
         .req_i       (dev_req_i[i]),
         .rel_i       (dev_rel_i[i]),
         .grant_out_o (grant_link[i+1]),
         .take_o      (take_vec[i]),
         .owned_o     (dev_own_o[i]),
         .rel_o       (rel_vec[i])
      );
   end

   // R8
   single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_own_o));

   // R7
   no_grant_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_w |-> (dev_own_o == '0));

   // R6
   owner_leaves_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(dev_own_o & dev_rel_i)) |=> (dev_own_o == '0));

   // R5
   foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_own_o != '0) && !(|(dev_own_o & dev_rel_i))) |=> $stable(dev_own_o));

endmodule

// File: tb/chain_arbiter_tb.sv
module chain_arbiter_tb;

   localparam int N  = 4;
   localparam int NV = 27;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] rel = '0;
   logic [N-1:0] own;
   logic         grant;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   chain_arbiter #(.N_DEV(N), .FLAT_OR(1'b0)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_req_i (req),
      .dev_rel_i (rel),
      .dev_own_o (own),
      .grant_o   (grant)
   );

   // {req id, req, rel, expected own, expected grant}; outputs due right after the edge
   localparam logic [16:0] VEC [NV] = '{
      {4'd1,  4'b0000, 4'b0000, 4'b0000, 1'b0},  // R1 idle
      {4'd2,  4'b0100, 4'b0000, 4'b0000, 1'b1},  // R2 offer
      {4'd2,  4'b0100, 4'b0000, 4'b0100, 1'b0},  // R2 dev2 owns
      {4'd4,  4'b0011, 4'b0000, 4'b0100, 1'b0},  // R4 others wait
      {4'd5,  4'b0011, 4'b0001, 4'b0100, 1'b0},  // R5 foreign release
      {4'd6,  4'b0011, 4'b0100, 4'b0000, 1'b0},  // R6 owner release
      {4'd6,  4'b0011, 4'b0000, 4'b0000, 1'b1},  // R6 gap then offer
      {4'd3,  4'b0011, 4'b0000, 4'b0001, 1'b0},  // R3 head wins
      {4'd6,  4'b0010, 4'b0001, 4'b0000, 1'b0},  // R6
      {4'd7,  4'b0010, 4'b0000, 4'b0000, 1'b1},  // R7 single pulse
      {4'd7,  4'b0010, 4'b0000, 4'b0010, 1'b0},  // R7 grant low with owner
      {4'd6,  4'b1000, 4'b0010, 4'b0000, 1'b0},  // R6
      {4'd2,  4'b1000, 4'b0000, 4'b0000, 1'b1},  // R2 tail request
      {4'd2,  4'b1000, 4'b0000, 4'b1000, 1'b0},  // R2 tail owns
      {4'd6,  4'b0000, 4'b1000, 4'b0000, 1'b0},  // R6
      {4'd9,  4'b0001, 4'b0000, 4'b0000, 1'b1},  // R9 offer
      {4'd9,  4'b0000, 4'b0000, 4'b0000, 1'b0},  // R9 withdrawn
      {4'd9,  4'b0000, 4'b0000, 4'b0000, 1'b0},  // R9 stays idle
      {4'd10, 4'b1001, 4'b0000, 4'b0000, 1'b1},  // R10
      {4'd10, 4'b1001, 4'b0000, 4'b0001, 1'b0},  // R10 head wins
      {4'd10, 4'b1001, 4'b0001, 4'b0000, 1'b0},  // R10
      {4'd10, 4'b1001, 4'b0000, 4'b0000, 1'b1},  // R10
      {4'd10, 4'b1001, 4'b0000, 4'b0001, 1'b0},  // R10 tail starved
      {4'd10, 4'b1000, 4'b0001, 4'b0000, 1'b0},  // R10
      {4'd10, 4'b1000, 4'b0000, 4'b0000, 1'b1},  // R10
      {4'd10, 4'b1000, 4'b0000, 4'b1000, 1'b0},  // R10 tail finally
      {4'd6,  4'b0000, 4'b1000, 4'b0000, 1'b0}   // R6
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 own in reset", int'(own), 0);
      chk("R1 grant in reset", int'(grant), 0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req = VEC[i][12:9];
         rel = VEC[i][8:5];
         @(posedge clk);
         #1;
         chk($sformatf("R%0d own vec %0d", VEC[i][16:13], i), int'(own), int'(VEC[i][4:1]));
         chk($sformatf("R%0d grant vec %0d", VEC[i][16:13], i), int'(grant), int'(VEC[i][0]));
      end

      // R3: all four request together, head device wins
      @(negedge clk); req = 4'b1111; rel = '0;
      @(posedge clk); @(posedge clk); #1;
      chk("R3 all request", int'(own), 4'b0001);

      // R1: asynchronous reset while the bus is owned
      @(negedge clk); rst_n = 1'b0; #1;
      chk("R1 async own", int'(own), 0);
      chk("R1 async grant", int'(grant), 0);
      req = '0;
      @(negedge clk); rst_n = 1'b1;

      // R5: release with no owner leaves the block idle
      @(negedge clk); rel = 4'b1111;
      @(posedge clk); #1;
      chk("R5 idle release own", int'(own), 0);
      chk("R5 idle release grant", int'(grant), 0);
      @(negedge clk); rel = '0; req = 4'b0010;
      @(posedge clk); @(posedge clk); #1;
      chk("R2 after reset", int'(own), 4'b0010);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

endmodule